// File: doc/BRIEF.md
# Peer Setup Message Parser

This block sits behind the byte transport that links a node to its connection manager. It assembles eight-byte, least-significant-byte-first signed messages, runs the setup handshake and keeps per-peer notification state up to date afterwards. A side-band flag comes with each message and tells whether a handle travelled with it. The handshake runs in a fixed order: a protocol version, then the local node ID, then any number of peer messages, and it finishes when a shared-memory announcement is accepted.

A peer message that carries a handle is a connect. A connect has no explicit vector number. Each connect registers the next vector of that peer, so the peer's vector count rises by one. A peer message without a handle is a disconnect and sets that peer's count back to zero. The counts, the local ID and the known node count drive a combinational doorbell range check, which says whether a given (peer, vector) pair may be rung.

A rejected message gives a one-cycle error pulse with a code. The message is then dropped and the parser stays in its current phase. Error codes: 1 version, 2 local ID, 3 value out of range, 4 shared-memory announcement, 5 vector table full, 6 bad disconnect, 7 peer beyond table capacity.

Top module: `peer_setup_parser`

## Requirements
- R1: Bytes are accepted on `inValid && inReady`, least significant byte first. A message is acted on only after its eighth byte, and `inReady` is low for exactly the one cycle that follows that byte. `inHandle` is sampled with the eighth byte.
- R2: The first accepted message must equal `PROTO_VER` (default 0) and carry no handle. Otherwise it produces code 1 and the parser keeps waiting for a version.
- R3: The second message must carry no handle and lie in 0..65535. If so, `localId` takes its value. Otherwise it produces code 2 and the parser keeps waiting for an ID. `localId` does not change once setup is done.
- R4: After the ID, any value below -1 or above 65535 produces code 3.
- R5: A value of -1 that carries a handle sets `setupDone`, and `setupDone` then stays high. A -1 without a handle, or any -1 once setup is done, produces code 4.
- R6: The N-th connect to a peer registers vector N-1. That peer's count goes up by one.
- R7: A connect to a peer that already holds `NUM_VECTORS` vectors produces code 5 and leaves the count unchanged.
- R8: A disconnect clears that peer's count. A disconnect naming `localId`, or an ID at or above `nodeCount`, produces code 6 and changes nothing.
- R9: An accepted connect to an ID at or above `nodeCount` raises `nodeCount` to ID+1. `nodeCount` never decreases.
- R10: A peer ID at or above `NUM_PEERS` (default 8) produces code 7 and changes no state.
- R11: `errPulse` lasts one cycle, in the cycle after the processing edge, and `errCode` is 0 whenever `errPulse` is low. The failing message leaves no other trace.
- R12: After reset `setupDone`, `nodeCount`, `errPulse`, `errCode` and `bellOk` are 0, and `inReady` is 1.
- R13: `bellOk` is high exactly when `bellPeer < nodeCount` and `bellVec` is below that peer's count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| inValid | input | 1 | Byte valid |
| inReady | output | 1 | Byte can be accepted |
| inData | input | 8 | Message byte |
| inHandle | input | 1 | A handle came with this message (taken with the eighth byte) |
| setupDone | output | 1 | Shared-memory announcement accepted |
| localId | output | 16 | Local node ID |
| nodeCount | output | 17 | Known node count |
| errPulse | output | 1 | One-cycle error strobe |
| errCode | output | 4 | Error code, 0 when idle |
| bellPeer | input | 16 | Doorbell destination peer |
| bellVec | input | 8 | Doorbell vector |
| bellOk | output | 1 | Doorbell target is registered |

## Verification
The bench sweeps every peer of a small table through one connect more than the vector limit, and checks the range check on every vector after each step. A design that takes the vector from the wrong end of the count, or lets the count wrap, gives the wrong `bellOk` there. Signed boundary values (-2, 65536, the largest and smallest 64-bit values) check the range decode. A byte-swapped version and a byte-swapped peer ID catch a reversed assembly order. The bench also disconnects the local ID and an unknown ID, and sends a second shared-memory announcement. A parser that accepted any of these would change counts or `setupDone` where the bench expects no change.

// File: rtl/psp_pkg.sv
package psp_pkg;
  localparam int ID_W  = 16;
  localparam int NODE_W = 17;
  localparam int VEC_W = 8;
  localparam longint MAX_ID = 65535;

  typedef enum logic [3:0] {
    ERR_NONE       = 4'd0,
    ERR_VERSION    = 4'd1,
    ERR_ID         = 4'd2,
    ERR_RANGE      = 4'd3,
    ERR_SHM        = 4'd4,
    ERR_VEC_FULL   = 4'd5,
    ERR_DISCONNECT = 4'd6,
    ERR_CAPACITY   = 4'd7
  } errCode_e;

  typedef enum logic [1:0] {
    PH_VERSION,
    PH_ID,
    PH_PEERS,
    PH_RUN
  } phase_e;

  typedef struct packed {
    logic consume;
    logic setLocal;
    logic bumpVec;
    logic clearVec;
  } strobe_t;
endpackage

// File: rtl/psp_datapath.sv
module psp_datapath #(
  parameter int NUM_PEERS   = 8,
  parameter int NUM_VECTORS = 3,
  localparam int CNT_W = $clog2(NUM_VECTORS + 1)
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  logic                         inValid,
  output logic                         inReady,
  input  logic [7:0]                   inData,
  input  logic                         inHandle,
  input  psp_pkg::strobe_t             strobe,
  output logic                         msgPending,
  output logic [63:0]                  msgVal,
  output logic                         msgHandle,
  output logic [CNT_W-1:0]             peerCnt,
  output logic [psp_pkg::NODE_W-1:0]   nodeCount,
  output logic [psp_pkg::ID_W-1:0]     localId,
  input  logic [psp_pkg::ID_W-1:0]     bellPeer,
  input  logic [psp_pkg::VEC_W-1:0]    bellVec,
  output logic                         bellOk
);
  import psp_pkg::*;

  logic [2:0] byteCnt;
  logic       accept;
  logic [NUM_PEERS*CNT_W-1:0] cntFlat;
  logic [CNT_W-1:0] bellCnt;
  logic [ID_W-1:0]  msgPeer;

  assign inReady = !msgPending;
  assign accept  = inValid && inReady;
  assign msgPeer = msgVal[ID_W-1:0];

  // byte assembly: newest byte enters at the top, so the first byte ends at [7:0]
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      byteCnt    <= '0;
      msgVal     <= '0;
      msgHandle  <= 1'b0;
      msgPending <= 1'b0;
    end else begin
      if (accept) begin
        msgVal  <= {inData, msgVal[63:8]};
        byteCnt <= byteCnt + 3'd1;
        if (byteCnt == 3'd7) begin
          msgPending <= 1'b1;
          msgHandle  <= inHandle;
        end
      end else if (strobe.consume) begin
        msgPending <= 1'b0;
      end
    end
  end

  // per-peer vector counters
  for (genvar g = 0; g < NUM_PEERS; g++) begin : gPeer
    logic [CNT_W-1:0] cntR;
    logic hit;
    assign hit = (msgPeer == ID_W'(g));
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)                       cntR <= '0;
      else if (hit && strobe.clearVec) cntR <= '0;
      else if (hit && strobe.bumpVec)  cntR <= cntR + CNT_W'(1);
    end
    assign cntFlat[g*CNT_W +: CNT_W] = cntR;
  end

  always_comb begin
    peerCnt = '0;
    bellCnt = '0;
    for (int i = 0; i < NUM_PEERS; i++) begin
      if (msgPeer == ID_W'(i))  peerCnt = cntFlat[i*CNT_W +: CNT_W];
      if (bellPeer == ID_W'(i)) bellCnt = cntFlat[i*CNT_W +: CNT_W];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      nodeCount <= '0;
      localId   <= '0;
    end else begin
      if (strobe.setLocal) localId <= msgPeer;
      if (strobe.bumpVec && ({1'b0, msgPeer} >= nodeCount))
        nodeCount <= {1'b0, msgPeer} + NODE_W'(1);
    end
  end

  assign bellOk = ({1'b0, bellPeer} < nodeCount) && (32'(bellVec) < 32'(bellCnt));
endmodule

// File: rtl/psp_control.sv
module psp_control #(
  parameter int     NUM_PEERS   = 8,
  parameter int     NUM_VECTORS = 3,
  parameter longint PROTO_VER   = 0,
  localparam int CNT_W = $clog2(NUM_VECTORS + 1)
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       msgPending,
  input  logic [63:0]                msgVal,
  input  logic                       msgHandle,
  input  logic [CNT_W-1:0]           peerCnt,
  input  logic [psp_pkg::NODE_W-1:0] nodeCount,
  input  logic [psp_pkg::ID_W-1:0]   localId,
  output psp_pkg::strobe_t           strobe,
  output logic                       setupDone,
  output logic                       errPulse,
  output logic [3:0]                 errCode
);
  import psp_pkg::*;

  phase_e   phase, phaseNext;
  errCode_e failCode;
  logic     fail, shmGo;
  logic signed [63:0] sv;
  logic [ID_W-1:0] peer;
  logic isVersion, inIdRange, outRange, isShm, beyondTable, vecFull, badDisc;

  assign sv          = $signed(msgVal);
  assign peer        = msgVal[ID_W-1:0];
  assign isVersion   = (msgVal == 64'(PROTO_VER));
  assign inIdRange   = (sv >= 64'sd0) && (sv <= 64'(MAX_ID));
  assign outRange    = (sv < -64'sd1) || (sv > 64'(MAX_ID));
  assign isShm       = (sv == -64'sd1);
  assign beyondTable = (32'(peer) >= 32'(NUM_PEERS));
  assign vecFull     = (32'(peerCnt) >= 32'(NUM_VECTORS));
  assign badDisc     = (peer == localId) || ({1'b0, peer} >= nodeCount);

  always_comb begin
    strobe    = '0;
    fail      = 1'b0;
    failCode  = ERR_NONE;
    shmGo     = 1'b0;
    phaseNext = phase;
    if (msgPending) begin
      strobe.consume = 1'b1;
      unique case (phase)
        PH_VERSION: begin
          if (isVersion && !msgHandle) phaseNext = PH_ID;
          else begin fail = 1'b1; failCode = ERR_VERSION; end
        end
        PH_ID: begin
          if (inIdRange && !msgHandle) begin
            strobe.setLocal = 1'b1;
            phaseNext = PH_PEERS;
          end else begin fail = 1'b1; failCode = ERR_ID; end
        end
        default: begin
          if (outRange) begin
            fail = 1'b1; failCode = ERR_RANGE;
          end else if (isShm) begin
            if (!msgHandle || phase == PH_RUN) begin fail = 1'b1; failCode = ERR_SHM; end
            else shmGo = 1'b1;
          end else if (beyondTable) begin
            fail = 1'b1; failCode = ERR_CAPACITY;
          end else if (msgHandle) begin
            if (vecFull) begin fail = 1'b1; failCode = ERR_VEC_FULL; end
            else strobe.bumpVec = 1'b1;
          end else begin
            if (badDisc) begin fail = 1'b1; failCode = ERR_DISCONNECT; end
            else strobe.clearVec = 1'b1;
          end
          if (shmGo) phaseNext = PH_RUN;
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phase    <= PH_VERSION;
      errPulse <= 1'b0;
      errCode  <= '0;
    end else begin
      phase    <= phaseNext;
      errPulse <= fail;
      errCode  <= fail ? failCode : ERR_NONE;
    end
  end

  assign setupDone = (phase == PH_RUN);
endmodule

// File: rtl/peer_setup_parser.sv
module peer_setup_parser #(
  parameter int     NUM_PEERS   = 8,
  parameter int     NUM_VECTORS = 3,
  parameter longint PROTO_VER   = 0
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        inValid,
  output logic        inReady,
  input  logic [7:0]  inData,
  input  logic        inHandle,
  output logic        setupDone,
  output logic [15:0] localId,
  output logic [16:0] nodeCount,
  output logic        errPulse,
  output logic [3:0]  errCode,
  input  logic [15:0] bellPeer,
  input  logic [7:0]  bellVec,
  output logic        bellOk
);
  localparam int CNT_W = $clog2(NUM_VECTORS + 1);

  psp_pkg::strobe_t strobe;
  logic             msgPending, msgHandle;
  logic [63:0]      msgVal;
  logic [CNT_W-1:0] peerCnt;

  psp_datapath #(.NUM_PEERS(NUM_PEERS), .NUM_VECTORS(NUM_VECTORS)) u_dp (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inReady(inReady),
    .inData(inData), .inHandle(inHandle), .strobe(strobe),
    .msgPending(msgPending), .msgVal(msgVal), .msgHandle(msgHandle),
    .peerCnt(peerCnt), .nodeCount(nodeCount), .localId(localId),
    .bellPeer(bellPeer), .bellVec(bellVec), .bellOk(bellOk)
  );

  psp_control #(.NUM_PEERS(NUM_PEERS), .NUM_VECTORS(NUM_VECTORS), .PROTO_VER(PROTO_VER)) u_ctl (
    .clk(clk), .rstN(rstN), .msgPending(msgPending), .msgVal(msgVal),
    .msgHandle(msgHandle), .peerCnt(peerCnt), .nodeCount(nodeCount),
    .localId(localId), .strobe(strobe), .setupDone(setupDone),
    .errPulse(errPulse), .errCode(errCode)
  );
endmodule

// File: rtl/psp_checker.sv
module psp_checker (
  input logic        clk,
  input logic        rstN,
  input logic        inReady,
  input logic        setupDone,
  input logic [15:0] localId,
  input logic [16:0] nodeCount,
  input logic        errPulse,
  input logic [3:0]  errCode,
  input logic [15:0] bellPeer,
  input logic        bellOk
);
  // R1: an error can only follow a cycle in which a complete message was held
  a_r1_err_after_hold: assert property (@(posedge clk) disable iff (!rstN)
    errPulse |-> !$past(inReady));
  // R11: single-cycle pulse, and the code is idle without a pulse
  a_r11_single_pulse: assert property (@(posedge clk) disable iff (!rstN)
    errPulse |=> !errPulse);
  a_r11_code_idle: assert property (@(posedge clk) disable iff (!rstN)
    !errPulse |-> errCode == 4'd0);
  a_r11_code_set: assert property (@(posedge clk) disable iff (!rstN)
    errPulse |-> errCode != 4'd0);
  // R5: completion is sticky
  a_r5_done_sticky: assert property (@(posedge clk) disable iff (!rstN)
    setupDone |=> setupDone);
  // R3: local ID frozen after setup
  a_r3_local_frozen: assert property (@(posedge clk) disable iff (!rstN)
    setupDone |-> $stable(localId));
  // R9: node count never shrinks
  a_r9_nodes_monotonic: assert property (@(posedge clk) disable iff (!rstN)
    nodeCount >= $past(nodeCount));
  // R13: a ring target must be a known node
  a_r13_bell_known: assert property (@(posedge clk) disable iff (!rstN)
    bellOk |-> ({1'b0, bellPeer} < nodeCount));
endmodule

bind peer_setup_parser psp_checker u_chk (
  .clk(clk), .rstN(rstN), .inReady(inReady), .setupDone(setupDone),
  .localId(localId), .nodeCount(nodeCount), .errPulse(errPulse),
  .errCode(errCode), .bellPeer(bellPeer), .bellOk(bellOk)
);

// File: tb/peer_setup_parser_bench.sv
module peer_setup_parser_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NP = 8;
  localparam int NV = 3;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        inValid = 1'b0;
  logic        inReady;
  logic [7:0]  inData = '0;
  logic        inHandle = 1'b0;
  logic        setupDone;
  logic [15:0] localId;
  logic [16:0] nodeCount;
  logic        errPulse;
  logic [3:0]  errCode;
  logic [15:0] bellPeer = '0;
  logic [7:0]  bellVec = '0;
  logic        bellOk;

  int checks = 0;
  int fails = 0;
  bit lastReady;
  bit readyBad = 0;
  bit ep;
  logic [3:0] ec;
  int expCnt [NP];
  int expNodes = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  peer_setup_parser #(.NUM_PEERS(NP), .NUM_VECTORS(NV), .PROTO_VER(0)) u_peer_setup_parser (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inReady(inReady), .inData(inData),
    .inHandle(inHandle), .setupDone(setupDone), .localId(localId),
    .nodeCount(nodeCount), .errPulse(errPulse), .errCode(errCode),
    .bellPeer(bellPeer), .bellVec(bellVec), .bellOk(bellOk)
  );

  task automatic chk(input string req, input longint act, input longint exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic sendMsg(input longint v, input bit h);
    for (int b = 0; b < 8; b++) begin
      @(negedge clk);
      if (!inReady) readyBad = 1;
      inValid = 1'b1;
      inData = v[8*b +: 8];
      inHandle = h;
      @(posedge clk);
    end
    @(negedge clk);
    inValid = 1'b0;
    inHandle = 1'b0;
    lastReady = inReady;
    @(posedge clk);
    @(negedge clk);
    ep = errPulse;
    ec = errCode;
  endtask

  task automatic expectMsg(input string req, input longint v, input bit h, input int code);
    sendMsg(v, h);
    chk({req, " code"}, longint'(ec), longint'(code));
    chk({req, " pulse"}, longint'(ep), longint'(code != 0));
  endtask

  task automatic bellCheck(input string req, input int p, input int v, input bit exp);
    bellPeer = 16'(p);
    bellVec = 8'(v);
    #1;
    chk(req, longint'(bellOk), longint'(exp));
  endtask

  task automatic finishRun();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    fails++;
    $display("FAIL watchdog expired");
    finishRun();
  end

  initial begin
    for (int i = 0; i < NP; i++) expCnt[i] = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R12 reset state
    chk("R12 setupDone", setupDone, 0);
    chk("R12 nodeCount", nodeCount, 0);
    chk("R12 errPulse", errPulse, 0);
    chk("R12 errCode", errCode, 0);
    chk("R12 inReady", inReady, 1);
    bellCheck("R12 bellOk", 0, 0, 0);

    // R2 version phase; R1 byte order (0 in low byte, 1 in high byte)
    expectMsg("R2 wrong version", 1, 0, 1);
    chk("R1 ready low after last byte", lastReady, 0);
    @(negedge clk);
    chk("R11 pulse one cycle", errPulse, 0);
    chk("R11 code idle", errCode, 0);
    expectMsg("R2 version with handle", 0, 1, 1);
    expectMsg("R1 byte order version", 64'h0100_0000_0000_0000, 0, 1);
    expectMsg("R2 version ok", 0, 0, 0);

    // R3 local ID
    expectMsg("R3 id with handle", 2, 1, 2);
    expectMsg("R3 id too big", 65536, 0, 2);
    expectMsg("R3 id negative", -1, 0, 2);
    chk("R11 setupDone untouched", setupDone, 0);
    expectMsg("R3 id ok", 2, 0, 0);
    chk("R3 localId", localId, 2);

    // R4 range
    expectMsg("R4 minus two", -2, 0, 3);
    expectMsg("R4 65536", 65536, 1, 3);
    expectMsg("R4 max", 64'h7fff_ffff_ffff_ffff, 1, 3);
    expectMsg("R4 min", 64'h8000_0000_0000_0000, 0, 3);
    // R10 capacity, R1 byte order of a peer ID
    expectMsg("R10 peer at table size", NP, 1, 7);
    expectMsg("R10 peer max", 65535, 1, 7);
    expectMsg("R1 swapped peer id", 64'h0500, 1, 7);
    chk("R10 nodeCount unchanged", nodeCount, 0);
    // R8 disconnects that must fail
    expectMsg("R8 disconnect unknown", 6, 0, 6);
    expectMsg("R8 disconnect local", 2, 0, 6);
    // R5 shared memory without handle
    expectMsg("R5 shm without handle", -1, 0, 4);
    chk("R5 not done", setupDone, 0);

    // R6 R7 R9 sweep of connects
    for (int i = 0; i < NP; i++) begin
      int p;
      p = (i * 3) % NP;
      for (int n = 1; n <= NV + 1; n++) begin
        if (n > NV) expectMsg("R7 vector full", p, 1, 5);
        else begin
          expectMsg("R6 connect", p, 1, 0);
          expCnt[p]++;
          if (p + 1 > expNodes) expNodes = p + 1;
        end
        chk("R9 nodeCount", nodeCount, expNodes);
        for (int v = 0; v <= NV; v++)
          bellCheck("R6 R13 bell after connect", p, v, v < expCnt[p]);
      end
    end

    // R5 completion
    expectMsg("R5 shm ok", -1, 1, 0);
    chk("R5 done", setupDone, 1);
    expectMsg("R5 second shm", -1, 1, 4);
    chk("R5 still done", setupDone, 1);

    // R8 disconnect and reconnect
    expectMsg("R8 disconnect peer", 3, 0, 0);
    expCnt[3] = 0;
    bellCheck("R8 cleared", 3, 0, 0);
    expectMsg("R8 disconnect local after setup", 2, 0, 6);
    bellCheck("R8 local kept", 2, NV - 1, 1);
    expectMsg("R6 reconnect", 3, 1, 0);
    expCnt[3] = 1;
    bellCheck("R6 reconnect vec0", 3, 0, 1);
    bellCheck("R6 reconnect vec1", 3, 1, 0);
    chk("R9 nodeCount kept", nodeCount, expNodes);
    chk("R3 localId kept", localId, 2);

    // R13 full sweep including a peer beyond the known nodes
    for (int p = 0; p <= NP; p++)
      for (int v = 0; v <= NV; v++)
        bellCheck("R13 final sweep", p, v, (p < expNodes) && (v < expCnt[p % NP]) && (p < NP));

    chk("R1 ready high while bytes flow", readyBad, 0);
    finishRun();
  end
endmodule